// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer that software reaches through a small register file on a fast bus clock. The counting logic runs on a separate slow functional clock. The counter counts upward from a programmed load value, and each count is paced by an optional power-of-two prescaler. When the counter passes its all-ones value while running, the block drives a reset pulse of fixed length and sets a sticky cause flag. The counter then starts again from the load value.

Every write to the control, load, trigger or key register is posted. The bus side keeps the written value, and a toggle handshake carries it into the slow domain. A per-register pending bit stays set until the slow domain has applied the write. Software must see that bit clear before it writes the same register again. Two two-word key sequences start and stop the counter. Software keeps the counter away from overflow by writing a new value to the trigger register, which copies the load value into the counter. The counter value, the run state and the cause flag come back to the bus domain through a snapshot handshake.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter is stopped, reads of the count, load, status and pending registers give zero, and the reset output is low. Register word addresses are: 0 control, 1 load, 2 trigger, 3 key, 4 pending, 5 count, 6 status (bit 0 cause flag, bit 1 running), 7 revision.
- R2: The low byte of the revision register returns the parameter REV_CODE, and the upper bits read zero.
- R3: A bus write to a posted register sets its pending bit on the next bus clock edge. The bit clears once the slow domain has applied the write. Pending bit positions are control 0, load 2, trigger 3, key 4; bit 1 and bits above 4 read zero.
- R4: A write to a posted register while its pending bit is set is dropped, and the earlier value remains in effect.
- R5: A trigger write whose value differs from the last applied trigger value loads the counter with the load register value, whether the counter is running or stopped. The last trigger value resets to zero.
- R6: A trigger write equal to the last applied trigger value leaves the counter unchanged.
- R7: Writing 0xBBBB and then 0x4444 to the key register (low 16 bits) starts the counter, and it then counts up.
- R8: Writing 0xAAAA and then 0x5555 to the key register stops the counter, and its value then holds.
- R9: A key write that does not complete a pending pair discards that partial sequence and leaves the run state unchanged. A second-word key with no first word before it also has no effect.
- R10: Control bit 5 enables the prescaler, and bits 4:2 hold the ratio exponent p. When enabled the counter advances every 2^p slow clock cycles; when disabled it advances every slow cycle.
- R11: A count step from all-ones drives the reset output high for exactly RST_LEN slow clock cycles, and the counter continues from the load value.
- R12: The status cause flag sets on overflow and stays set until block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock for register access |
| fclk | input | 1 | Slow functional clock for counting |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_we | input | 1 | Register write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst_o | output | 1 | Watchdog reset pulse, slow clock domain |

## Verification
The checker takes for granted that rst_n is released cleanly in both clock domains. It also assumes the bus write strobe lasts exactly one bus cycle. A write during a pending interval is allowed by the design and is simply dropped, so the pending-set check applies only to accepted writes. The bench holds each write strobe for one cycle, and it polls the pending register after each write, except in the deliberate back-to-back write case. It keeps overflow intervals long enough that every stop sequence completes before a second overflow could start.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [15:0] KEY_STOP_A = 16'hAAAA;
  localparam logic [15:0] KEY_STOP_B = 16'h5555;
  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;

  localparam int NUM_CH  = 4;
  localparam int CH_CTRL = 0;
  localparam int CH_LOAD = 1;
  localparam int CH_TRIG = 2;
  localparam int CH_KEY  = 3;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_TRIG  = 3'd2,
    A_KEY   = 3'd3,
    A_PEND  = 3'd4,
    A_COUNT = 3'd5,
    A_STAT  = 3'd6,
    A_REV   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    K_IDLE     = 2'd0,
    K_ARM_STOP = 2'd1,
    K_ARM_RUN  = 2'd2
  } key_st_e;

  // Next key-sequence state: only a first word arms, everything else idles
  function automatic key_st_e key_step(key_st_e st, logic [15:0] k);
    key_st_e nx;
    nx = K_IDLE;
    if (st == K_IDLE) begin
      if (k == KEY_RUN_A)       nx = K_ARM_RUN;
      else if (k == KEY_STOP_A) nx = K_ARM_STOP;
    end
    return nx;
  endfunction

  // Run state after a key write
  function automatic logic key_run(key_st_e st, logic [15:0] k, logic run);
    logic r;
    r = run;
    if (st == K_ARM_RUN && k == KEY_RUN_B)   r = 1'b1;
    if (st == K_ARM_STOP && k == KEY_STOP_B) r = 1'b0;
    return r;
  endfunction

  // Prescaler terminal count for ratio exponent p: 2^p - 1
  function automatic logic [6:0] pre_limit(logic [2:0] ptv);
    return (7'd1 << ptv) - 7'd1;
  endfunction

  // Channel pending flags to register bit positions
  function automatic logic [31:0] pend_word(logic [NUM_CH-1:0] p);
    return {27'd0, p[CH_KEY], p[CH_TRIG], p[CH_LOAD], 1'b0, p[CH_CTRL]};
  endfunction

endpackage

// File: rtl/kwdt_post_ch.sv
module kwdt_post_ch #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         bclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         acc_o,
  output logic         pend_o,
  output logic [W-1:0] data_o,
  output logic         stb_o
);
  logic              req_q;
  logic              ack_q;
  logic [STAGES-1:0] req_s;
  logic [STAGES-1:0] ack_s;

  assign pend_o = req_q ^ ack_s[STAGES-1];
  assign acc_o  = wr_i & ~pend_o;

  // bus side: hold value, toggle request
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      data_o <= '0;
      ack_s  <= '0;
    end else begin
      ack_s <= {ack_s[STAGES-2:0], ack_q};
      if (acc_o) begin
        req_q  <= ~req_q;
        data_o <= wdata_i;
      end
    end
  end

  // slow side: detect request edge, echo it back
  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_s <= '0;
      ack_q <= 1'b0;
    end else begin
      req_s <= {req_s[STAGES-2:0], req_q};
      ack_q <= req_s[STAGES-1];
    end
  end

  assign stb_o = req_s[STAGES-1] ^ ack_q;
endmodule

// File: rtl/kwdt_snap.sv
module kwdt_snap #(
  parameter int W      = 34,
  parameter int STAGES = 2
) (
  input  logic         fclk,
  input  logic         bclk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] val_o
);
  logic              req_q;
  logic              ack_q;
  logic [W-1:0]      hold_q;
  logic [STAGES-1:0] req_s;
  logic [STAGES-1:0] ack_s;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
      ack_s  <= '0;
    end else begin
      ack_s <= {ack_s[STAGES-2:0], ack_q};
      if (ack_s[STAGES-1] == req_q) begin
        hold_q <= src_i;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_s <= '0;
      ack_q <= 1'b0;
      val_o <= '0;
    end else begin
      req_s <= {req_s[STAGES-2:0], req_q};
      if (req_s[STAGES-1] != ack_q) begin
        val_o <= hold_q;
        ack_q <= req_s[STAGES-1];
      end
    end
  end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RST_LEN = 8
) (
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             ctrl_stb,
  input  logic [3:0]       ctrl_d,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_d,
  input  logic             trig_stb,
  input  logic [31:0]      trig_d,
  input  logic             key_stb,
  input  logic [15:0]      key_d,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             cause_o,
  output logic             rst_o,
  output logic             tick_o,
  output logic             ovf_o,
  output logic             reload_o
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic             pre_en_q;
  logic [2:0]       ptv_q;
  logic [CNT_W-1:0] load_q;
  logic [31:0]      trig_last_q;
  key_st_e          key_st_q;
  logic             run_q;
  logic [6:0]       pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    rst_cnt_q;
  logic             cause_q;

  assign reload_o = trig_stb && (trig_d != trig_last_q);
  assign tick_o   = run_q && (!pre_en_q || (pre_q >= pre_limit(ptv_q)));
  assign ovf_o    = tick_o && (cnt_q == '1) && !reload_o;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q    <= 1'b0;
      ptv_q       <= '0;
      load_q      <= '0;
      trig_last_q <= '0;
      key_st_q    <= K_IDLE;
      run_q       <= 1'b0;
    end else begin
      if (ctrl_stb) {pre_en_q, ptv_q} <= ctrl_d;
      if (load_stb) load_q <= load_d;
      if (trig_stb) trig_last_q <= trig_d;
      if (key_stb) begin
        key_st_q <= key_step(key_st_q, key_d);
        run_q    <= key_run(key_st_q, key_d, run_q);
      end
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      cnt_q     <= '0;
      rst_cnt_q <= '0;
      cause_q   <= 1'b0;
    end else begin
      if (!run_q || tick_o) pre_q <= '0;
      else                  pre_q <= pre_q + 7'd1;

      if (reload_o || ovf_o) cnt_q <= load_q;
      else if (tick_o)       cnt_q <= cnt_q + 1'b1;

      if (ovf_o)                rst_cnt_q <= RW'(RST_LEN);
      else if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;

      if (ovf_o) cause_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign run_o   = run_q;
  assign cause_o = cause_q;
  assign rst_o   = (rst_cnt_q != '0);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int         CNT_W       = 32,
  parameter int         RST_LEN     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REV_CODE    = 8'h21
) (
  input  logic        bclk,
  input  logic        fclk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_o
);
  localparam int SNAP_W = CNT_W + 2;

  logic [NUM_CH-1:0] wr_acc_w;
  logic [NUM_CH-1:0] pend_w;
  logic [NUM_CH-1:0] stb_w;
  logic [31:0]       ch_data [NUM_CH];

  logic [CNT_W-1:0]  cnt_w;
  logic              run_w;
  logic              cause_w;
  logic              tick_w;
  logic              ovf_w;
  logic              reload_w;
  logic [SNAP_W-1:0] snap_w;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    kwdt_post_ch #(.W(32), .STAGES(SYNC_STAGES)) ch_i (
      .bclk    (bclk),
      .fclk    (fclk),
      .rst_n   (rst_n),
      .wr_i    (bus_we && (bus_addr == 3'(i))),
      .wdata_i (bus_wdata),
      .acc_o   (wr_acc_w[i]),
      .pend_o  (pend_w[i]),
      .data_o  (ch_data[i]),
      .stb_o   (stb_w[i])
    );
  end

  kwdt_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) core_i (
    .fclk     (fclk),
    .rst_n    (rst_n),
    .ctrl_stb (stb_w[CH_CTRL]),
    .ctrl_d   (ch_data[CH_CTRL][5:2]),
    .load_stb (stb_w[CH_LOAD]),
    .load_d   (ch_data[CH_LOAD][CNT_W-1:0]),
    .trig_stb (stb_w[CH_TRIG]),
    .trig_d   (ch_data[CH_TRIG]),
    .key_stb  (stb_w[CH_KEY]),
    .key_d    (ch_data[CH_KEY][15:0]),
    .cnt_o    (cnt_w),
    .run_o    (run_w),
    .cause_o  (cause_w),
    .rst_o    (wdt_rst_o),
    .tick_o   (tick_w),
    .ovf_o    (ovf_w),
    .reload_o (reload_w)
  );

  kwdt_snap #(.W(SNAP_W), .STAGES(SYNC_STAGES)) snap_i (
    .fclk  (fclk),
    .bclk  (bclk),
    .rst_n (rst_n),
    .src_i ({run_w, cause_w, cnt_w}),
    .val_o (snap_w)
  );

  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      A_CTRL, A_LOAD, A_TRIG, A_KEY: bus_rdata = ch_data[bus_addr[1:0]];
      A_PEND:  bus_rdata = pend_word(pend_w);
      A_COUNT: bus_rdata[CNT_W-1:0] = snap_w[CNT_W-1:0];
      A_STAT:  bus_rdata[1:0] = {snap_w[SNAP_W-1], snap_w[SNAP_W-2]};
      A_REV:   bus_rdata[7:0] = REV_CODE;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             bclk,
  input logic             fclk,
  input logic             rst_n,
  input logic [3:0]       wr_acc,
  input logic [3:0]       pend,
  input logic             key_stb,
  input logic             run,
  input logic             reload,
  input logic             ovf,
  input logic             rst_o,
  input logic             cause,
  input logic [CNT_W-1:0] cnt
);
  // R3
  pend_set_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (wr_acc != 4'd0) |=> ((pend & $past(wr_acc)) == $past(wr_acc)));

  // R8
  stopped_hold_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt));

  // R9
  run_key_only_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    !key_stb |=> $stable(run));

  // R11
  ovf_rst_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    ovf |=> rst_o);

  // R11
  rst_src_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(ovf));

  // R12
  cause_sticky_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    cause |=> cause);
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) chk_i (
  .bclk    (bclk),
  .fclk    (fclk),
  .rst_n   (rst_n),
  .wr_acc  (wr_acc_w),
  .pend    (pend_w),
  .key_stb (stb_w[3]),
  .run     (run_w),
  .reload  (reload_w),
  .ovf     (ovf_w),
  .rst_o   (wdt_rst_o),
  .cause   (cause_w),
  .cnt     (cnt_w)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int RST_LEN = 8;
  localparam logic [7:0] REV = 8'h21;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_LOAD = 3'd1, AD_TRIG = 3'd2, AD_KEY = 3'd3;
  localparam logic [2:0] AD_PEND = 3'd4, AD_CNT = 3'd5, AD_STAT = 3'd6, AD_REV = 3'd7;

  logic bclk = 0, fclk = 0, rst_n = 0;
  logic we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic wrst;
  int total = 0, bad = 0;
  logic [31:0] tv = 0;

  always #4 bclk = ~bclk;
  always #20 fclk = ~fclk;

  kwdt_top #(.RST_LEN(RST_LEN), .REV_CODE(REV)) dut_i (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wdt_rst_o(wrst));

  function automatic longint exp_ticks(logic [31:0] ld, bit en, int p);
    longint steps = 64'h1_0000_0000 - longint'(ld);
    return en ? steps * (longint'(1) << p) : steps;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic bwr(logic [2:0] a, logic [31:0] d);
    @(negedge bclk); we = 1; addr = a; wdata = d;
    @(negedge bclk); we = 0;
  endtask

  task automatic brd(logic [2:0] a, output logic [31:0] d);
    @(negedge bclk); addr = a; #1 d = rdata;
  endtask

  task automatic fwait(int n);
    repeat (n) @(negedge fclk);
  endtask

  task automatic wait_pend(logic [31:0] mask);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      brd(AD_PEND, v);
      if ((v & mask) == 0) return;
    end
    chk("R3 pending never cleared", v & mask, 0);
  endtask

  task automatic put(logic [2:0] a, logic [31:0] d);
    logic [31:0] m;
    case (a)
      AD_CTRL: m = 32'h01;
      AD_LOAD: m = 32'h04;
      AD_TRIG: m = 32'h08;
      default: m = 32'h10;
    endcase
    bwr(a, d);
    wait_pend(m);
  endtask

  task automatic retrig();
    tv = tv + 1;
    put(AD_TRIG, tv);
  endtask

  task automatic ovf_run(logic [31:0] ld, bit en, int p);
    logic [31:0] v;
    longint e;
    int n, len;
    put(AD_CTRL, {26'd0, en, 3'(p), 2'd0});
    put(AD_LOAD, ld);
    retrig();
    fwait(12);
    brd(AD_CNT, v); chk("R5 reload before run", v, ld);
    put(AD_KEY, 32'hBBBB);
    put(AD_KEY, 32'h4444);
    n = 0;
    while (!wrst && n < 5000) begin @(negedge fclk); n++; end
    e = exp_ticks(ld, en, p);
    total++;
    if (longint'(n) + 4 < e || longint'(n) > e + 3) begin
      bad++;
      $display("FAIL R10 overflow interval act=%0d exp=%0d (en=%0d p=%0d)", n, e, en, p);
    end
    len = 0;
    while (wrst && len < 100) begin @(negedge fclk); len++; end
    chk("R11 reset pulse length", len, RST_LEN);
    put(AD_KEY, 32'hAAAA);
    put(AD_KEY, 32'h5555);
    fwait(12);
    brd(AD_CNT, v);
    chk("R11 count restarts from load", (v >= ld && v < ld + 40) ? 1 : 0, 1);
    brd(AD_STAT, v);
    chk("R8 stopped after overflow run", v[1], 0);
    chk("R12 cause flag set", v[0], 1);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    report();
  end

  initial begin
    logic [31:0] v, c1, c2;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge bclk);
    rst_n = 1;
    fwait(10);

    // R1 reset state
    brd(AD_PEND, v); chk("R1 pending", v, 0);
    brd(AD_CNT, v);  chk("R1 count", v, 0);
    brd(AD_STAT, v); chk("R1 status", v, 0);
    brd(AD_LOAD, v); chk("R1 load", v, 0);
    chk("R1 reset output", wrst, 0);
    // R2
    brd(AD_REV, v); chk("R2 revision", v, {24'd0, REV});

    // R3 pending bit positions
    bwr(AD_CTRL, 32'h0); brd(AD_PEND, v); chk("R3 ctrl bit0", v, 32'h01); wait_pend(32'h1f);
    bwr(AD_LOAD, 32'h0); brd(AD_PEND, v); chk("R3 load bit2", v, 32'h04); wait_pend(32'h1f);
    bwr(AD_KEY, 32'h1234); brd(AD_PEND, v); chk("R3 key bit4", v, 32'h10); wait_pend(32'h1f);
    bwr(AD_TRIG, 32'h0); brd(AD_PEND, v); chk("R3 trig bit3", v, 32'h08); wait_pend(32'h1f);
    brd(AD_PEND, v); chk("R3 all clear", v, 0);

    // R4 write while pending is dropped
    bwr(AD_LOAD, 32'h0000_1111);
    bwr(AD_LOAD, 32'h0000_2222);
    wait_pend(32'h04);
    brd(AD_LOAD, v); chk("R4 load shadow", v, 32'h0000_1111);
    retrig(); fwait(12);
    brd(AD_CNT, v); chk("R4 count from first load", v, 32'h0000_1111);

    // R5 / R6 stopped reloads
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      put(AD_LOAD, a); retrig(); fwait(12);
      brd(AD_CNT, v); chk("R5 trigger reload", v, a);
      put(AD_LOAD, b); put(AD_TRIG, tv); fwait(12);
      brd(AD_CNT, v); chk("R6 same trigger ignored", v, a);
    end

    // R7 start, R9 broken pair, R8 stop
    put(AD_CTRL, 32'h0);
    put(AD_LOAD, 32'h0000_1000); retrig();
    put(AD_KEY, 32'h4444); fwait(12);
    brd(AD_STAT, v); chk("R9 lone second word", v[1], 0);
    put(AD_KEY, 32'hBBBB); put(AD_KEY, 32'h4444); fwait(12);
    brd(AD_CNT, c1); fwait(30); brd(AD_CNT, c2);
    chk("R7 counting up", (c2 > c1) ? 1 : 0, 1);
    brd(AD_STAT, v); chk("R7 running", v[1], 1);
    put(AD_KEY, 32'hAAAA); put(AD_KEY, 32'h4444); fwait(12);
    brd(AD_STAT, v); chk("R9 mixed pair keeps running", v[1], 1);
    put(AD_KEY, 32'hAAAA); put(AD_KEY, 32'h5555); fwait(12);
    brd(AD_CNT, c1); fwait(30); brd(AD_CNT, c2);
    chk("R8 count frozen", c2, c1);
    brd(AD_STAT, v); chk("R8 stopped", v[1], 0);
    put(AD_KEY, 32'hBBBB); put(AD_KEY, 32'hAAAA); put(AD_KEY, 32'h4444); fwait(12);
    brd(AD_STAT, v); chk("R9 broken start", v[1], 0);
    brd(AD_CNT, v); chk("R9 count unchanged", v, c2);
    brd(AD_STAT, v); chk("R12 no cause yet", v[0], 0);

    // R10 / R11 / R12 overflow runs
    ovf_run(32'hFFFF_FFD0, 1'b0, 0);
    ovf_run(32'hFFFF_FFCE, 1'b1, 2);
    ovf_run(32'hFFFF_FFC0, 1'b1, 0);
    for (int i = 0; i < 6; i++) begin
      int stp, p;
      bit en;
      stp = 48 + int'($urandom % 24);
      p = int'($urandom % 3);
      en = 1'($urandom % 2);
      ovf_run(32'hFFFF_FFFF - 32'(stp) + 1, en, p);
    end
    put(AD_LOAD, 32'h5); retrig(); fwait(12);
    brd(AD_STAT, v); chk("R12 cause still set", v[0], 1);

    report();
  end
endmodule